// File: doc/BRIEF.md
# Dual PHY data interface selector

This block sits between two on-chip PHYs, a 1 Mbps phone-line PHY and a 10BASE-T PHY, and the single data and status interface facing the MAC. It decides which PHY drives that interface, or whether the interface is switched off. It also decodes the static strap pins into a data-interface type, a management-interface type and the two management addresses.

The source choice has two control paths. When the external select pin is low and the external isolate pin is high, the block is in managed mode. The choice then comes from one isolate bit in each PHY's control register. In every other pin state the block is in external control mode, and the two pins decide on their own. The straps are captured while reset is asserted and held once it is released.

The receive stream of the chosen PHY passes to the MAC side over a valid/ready handshake. A transfer happens on a cycle where `rx_valid` and `rx_ready` are both high. The downstream `rx_ready` is passed back only to the selected PHY. The unselected PHY always sees ready low, so it is held off and loses no data. While the output-enable is low, both PHYs see ready low, and `rx_valid` and `rx_data` are zero.

Top module: `phy_data_sel`

## Requirements
- R1: Strap decode uses `cfg_force_serial` and `cfg_mii_sel`. If `cfg_force_serial`=1, the result is `data_is_mii`=0 and `mgmt_is_mdio`=1, whatever `cfg_mii_sel` is. Otherwise `cfg_mii_sel`=1 gives `data_is_mii`=1 and `mgmt_is_mdio`=1, and `cfg_mii_sel`=0 gives `data_is_mii`=0 and `mgmt_is_mdio`=0 (serial management).
- R2: Strap inputs, including `cfg_addr_hi`, are sampled while `rst_n` is low. The value present at reset release is held. Changes on the straps after that have no effect on `data_is_mii`, `mgmt_is_mdio`, `addr_phone` or `addr_tbt`.
- R3: With `cfg_addr_hi`=0, `addr_phone`=0 and `addr_tbt`=1. With `cfg_addr_hi`=1, `addr_phone`=2 and `addr_tbt`=3.
- R4: Managed mode applies when `pin_src_sel`=0 and `pin_isolate`=1. `reg_iso_phone`=0 with `reg_iso_tbt`=1 gives `src_sel`=0 (phone-line) and `out_en`=1. `reg_iso_phone`=1 with `reg_iso_tbt`=0 gives `src_sel`=1 (10BASE-T) and `out_en`=1. `src_sel`, `out_en`, `src_valid` and `cfg_error` are registered and follow their inputs one clock later.
- R5: In managed mode with both register isolate bits at 1, `out_en`=0 (high impedance) and `src_valid`=1.
- R6: In managed mode with both register isolate bits at 0, `out_en`=0, `src_valid`=0 and `cfg_error`=1. `cfg_error` stays set until the first cycle with a valid combination, and that cycle clears it.
- R7: In external control mode with `pin_isolate`=0, `out_en`=1 and `src_sel` equals `pin_src_sel`. The register isolate bits are ignored.
- R8: With `pin_isolate`=1 and `pin_src_sel`=1, `out_en`=0, whatever the register bits are.
- R9: When `out_en`=1, `rx_data` and `rx_valid` are those of the PHY named by `src_sel` (0 phone-line, 1 10BASE-T). When `out_en`=0, both are 0.
- R10: `rx_ready` is forwarded only to the selected PHY's ready output. The other PHY's ready is 0, and both are 0 when `out_en`=0.
- R11: While `rst_n` is low, `out_en`, `src_sel`, `src_valid` and `cfg_error` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; straps captured while low |
| cfg_force_serial | input | 1 | Strap: forces serial data with MDC/MDIO management |
| cfg_mii_sel | input | 1 | Strap: 1 MII data, 0 serial data |
| cfg_addr_hi | input | 1 | Strap: adds 2 to both management addresses |
| pin_isolate | input | 1 | External isolate pin |
| pin_src_sel | input | 1 | External PHY select pin (1 = 10BASE-T) |
| reg_iso_phone | input | 1 | Isolate bit from the phone-line PHY control register |
| reg_iso_tbt | input | 1 | Isolate bit from the 10BASE-T PHY control register |
| data_is_mii | output | 1 | Decoded data interface, 1 = MII |
| mgmt_is_mdio | output | 1 | Decoded management interface, 1 = MDC/MDIO |
| addr_phone | output | 5 | Management address of the phone-line PHY |
| addr_tbt | output | 5 | Management address of the 10BASE-T PHY |
| src_sel | output | 1 | Active PHY, 0 phone-line, 1 10BASE-T |
| src_valid | output | 1 | Current select combination is legal |
| out_en | output | 1 | Interface driven (0 = high impedance) |
| cfg_error | output | 1 | Illegal managed-mode combination seen |
| phone_valid | input | 1 | Phone-line PHY stream valid |
| phone_data | input | DW | Phone-line PHY receive data and status |
| phone_ready | output | 1 | Ready back to phone-line PHY |
| tbt_valid | input | 1 | 10BASE-T PHY stream valid |
| tbt_data | input | DW | 10BASE-T PHY receive data and status |
| tbt_ready | output | 1 | Ready back to 10BASE-T PHY |
| rx_valid | output | 1 | MAC-side stream valid |
| rx_data | output | DW | MAC-side data and status |
| rx_ready | input | 1 | MAC-side ready |

## Verification
All four register-bit combinations are applied in managed mode. This separates the two selections, the high-impedance case and the illegal case, and shows that the error flag clears on a later legal write. External control mode is tried with each select pin level while isolate is low, and again with isolate high. In both cases the register bits are set to values that would select differently in managed mode, so the bench can tell whether the pins or the registers took control. The two PHYs carry different data on the stream path, so a swapped or leaking mux shows up on the output. The straps are changed after reset release to confirm they are held, and three strap sets plus both address levels cover the decode.

// File: rtl/phy_sel_pkg.sv
package phy_sel_pkg;
  typedef enum logic {SRC_PHONE = 1'b0, SRC_TBT = 1'b1} src_e;
  localparam int ADDR_W = 5;
  typedef struct packed {
    logic force_serial;
    logic mii_sel;
    logic addr_hi;
  } strap_t;
endpackage

// File: rtl/strap_capture.sv
module strap_capture
  import phy_sel_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  strap_t        pins,
  output logic          data_is_mii,
  output logic          mgmt_is_mdio,
  output logic [AW-1:0] addr_phone,
  output logic [AW-1:0] addr_tbt
);
  strap_t held_q;

  always_ff @(posedge clk) begin
    if (!rst_n) held_q <= pins;
  end

  assign data_is_mii  = !held_q.force_serial && held_q.mii_sel;
  assign mgmt_is_mdio = held_q.force_serial || held_q.mii_sel;

  always_comb begin
    addr_phone    = '0;
    addr_phone[1] = held_q.addr_hi;
    addr_tbt      = addr_phone;
    addr_tbt[0]   = 1'b1;
  end
endmodule

// File: rtl/src_decode.sv
module src_decode
  import phy_sel_pkg::*;
(
  input  logic pin_isolate,
  input  logic pin_src_sel,
  input  logic reg_iso_phone,
  input  logic reg_iso_tbt,
  output logic en,
  output src_e src,
  output logic legal
);
  logic managed;
  assign managed = pin_isolate && !pin_src_sel;

  always_comb begin
    if (managed) begin
      en    = reg_iso_phone ^ reg_iso_tbt;
      src   = reg_iso_phone ? SRC_TBT : SRC_PHONE;
      legal = reg_iso_phone || reg_iso_tbt;
    end else begin
      en    = !pin_isolate;
      src   = pin_src_sel ? SRC_TBT : SRC_PHONE;
      legal = 1'b1;
    end
  end
endmodule

// File: rtl/stream_mux.sv
module stream_mux #(
  parameter int DW = 8,
  parameter int N  = 2,
  localparam int SW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          en,
  input  logic [SW-1:0] sel,
  input  logic [N-1:0]  in_valid,
  input  logic [DW-1:0] in_data [N],
  output logic [N-1:0]  in_ready,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  input  logic          out_ready
);
  for (genvar g = 0; g < N; g++) begin : g_rdy
    assign in_ready[g] = en && (sel == SW'(g)) && out_ready;
  end

  always_comb begin
    out_valid = 1'b0;
    out_data  = '0;
    for (int i = 0; i < N; i++) begin
      if (en && sel == SW'(i)) begin
        out_valid = in_valid[i];
        out_data  = in_data[i];
      end
    end
  end
endmodule

// File: rtl/phy_data_sel.sv
module phy_data_sel
  import phy_sel_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_force_serial,
  input  logic              cfg_mii_sel,
  input  logic              cfg_addr_hi,
  input  logic              pin_isolate,
  input  logic              pin_src_sel,
  input  logic              reg_iso_phone,
  input  logic              reg_iso_tbt,
  output logic              data_is_mii,
  output logic              mgmt_is_mdio,
  output logic [ADDR_W-1:0] addr_phone,
  output logic [ADDR_W-1:0] addr_tbt,
  output logic              src_sel,
  output logic              src_valid,
  output logic              out_en,
  output logic              cfg_error,
  input  logic              phone_valid,
  input  logic [DW-1:0]     phone_data,
  output logic              phone_ready,
  input  logic              tbt_valid,
  input  logic [DW-1:0]     tbt_data,
  output logic              tbt_ready,
  output logic              rx_valid,
  output logic [DW-1:0]     rx_data,
  input  logic              rx_ready
);
  strap_t strap_pins;
  assign strap_pins = '{force_serial: cfg_force_serial, mii_sel: cfg_mii_sel,
                        addr_hi: cfg_addr_hi};

  strap_capture #(.AW(ADDR_W)) u_strap (
    .clk(clk), .rst_n(rst_n), .pins(strap_pins),
    .data_is_mii(data_is_mii), .mgmt_is_mdio(mgmt_is_mdio),
    .addr_phone(addr_phone), .addr_tbt(addr_tbt)
  );

  logic dec_en, dec_legal;
  src_e dec_src;
  src_decode u_dec (
    .pin_isolate(pin_isolate), .pin_src_sel(pin_src_sel),
    .reg_iso_phone(reg_iso_phone), .reg_iso_tbt(reg_iso_tbt),
    .en(dec_en), .src(dec_src), .legal(dec_legal)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_en    <= 1'b0;
      src_sel   <= 1'b0;
      src_valid <= 1'b0;
      cfg_error <= 1'b0;
    end else begin
      out_en    <= dec_en;
      src_sel   <= dec_src;
      src_valid <= dec_legal;
      if (!dec_legal)     cfg_error <= 1'b1;
      else if (cfg_error) cfg_error <= 1'b0;
    end
  end

  logic [DW-1:0] in_data [2];
  logic [1:0]    in_ready;
  assign in_data[0] = phone_data;
  assign in_data[1] = tbt_data;
  assign phone_ready = in_ready[0];
  assign tbt_ready   = in_ready[1];

  stream_mux #(.DW(DW), .N(2)) u_mux (
    .en(out_en), .sel(src_sel), .in_valid({tbt_valid, phone_valid}),
    .in_data(in_data), .in_ready(in_ready), .out_valid(rx_valid),
    .out_data(rx_data), .out_ready(rx_ready)
  );
endmodule

// File: rtl/phy_data_sel_chk.sv
module phy_data_sel_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pin_isolate,
  input logic          pin_src_sel,
  input logic          reg_iso_phone,
  input logic          reg_iso_tbt,
  input logic          data_is_mii,
  input logic          mgmt_is_mdio,
  input logic [4:0]    addr_phone,
  input logic [4:0]    addr_tbt,
  input logic          src_sel,
  input logic          out_en,
  input logic          cfg_error,
  input logic          phone_ready,
  input logic          tbt_ready,
  input logic          rx_valid,
  input logic [DW-1:0] rx_data
);
  p_strap_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(data_is_mii) && $stable(mgmt_is_mdio)
                     && $stable(addr_phone) && $stable(addr_tbt));

  p_bad_combo_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_isolate && !pin_src_sel && !reg_iso_phone && !reg_iso_tbt)
      |=> !out_en && cfg_error);

  p_ext_enable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_isolate |=> out_en && (src_sel == $past(pin_src_sel)));

  p_ext_hiz_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_isolate && pin_src_sel) |=> !out_en);

  p_quiet_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !out_en |-> !rx_valid && (rx_data == '0));

  p_ready_one_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({phone_ready, tbt_ready}) && (out_en || !(phone_ready || tbt_ready)));
endmodule

bind phy_data_sel phy_data_sel_chk #(.DW(DW)) u_chk (.*);

// File: tb/phy_data_sel_tb.sv
module phy_data_sel_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;

  logic clk = 0, rst_n = 0;
  logic cfg_force_serial = 0, cfg_mii_sel = 1, cfg_addr_hi = 0;
  logic pin_isolate = 1, pin_src_sel = 0, reg_iso_phone = 1, reg_iso_tbt = 1;
  logic data_is_mii, mgmt_is_mdio, src_sel, src_valid, out_en, cfg_error;
  logic [4:0] addr_phone, addr_tbt;
  logic phone_valid = 0, tbt_valid = 0, rx_ready = 0;
  logic [DW-1:0] phone_data = 8'h11, tbt_data = 8'hA5;
  logic phone_ready, tbt_ready, rx_valid;
  logic [DW-1:0] rx_data;
  int n_checks = 0, n_errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  phy_data_sel #(.DW(DW)) u_dut (.*);

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic step(int n = 1);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset(logic fs, logic ms, logic ah);
    @(negedge clk);
    rst_n = 0; cfg_force_serial = fs; cfg_mii_sel = ms; cfg_addr_hi = ah;
    step(2);
    rst_n = 1;
    step();
  endtask

  task automatic t_reset_state;
    @(negedge clk);
    rst_n = 0; pin_isolate = 0; pin_src_sel = 1;
    step(2);
    check("R11 out_en", out_en, 0);
    check("R11 src_sel", src_sel, 0);
    check("R11 src_valid", src_valid, 0);
    check("R11 cfg_error", cfg_error, 0);
    pin_isolate = 1; pin_src_sel = 0;
  endtask

  task automatic t_straps;
    do_reset(0, 1, 0);
    check("R1 mii data", data_is_mii, 1);
    check("R1 mii mgmt", mgmt_is_mdio, 1);
    check("R3 addr phone lo", addr_phone, 0);
    check("R3 addr tbt lo", addr_tbt, 1);
    cfg_force_serial = 1; cfg_mii_sel = 0; cfg_addr_hi = 1;
    step(3);
    check("R2 hold data", data_is_mii, 1);
    check("R2 hold mgmt", mgmt_is_mdio, 1);
    check("R2 hold addr", addr_phone, 0);
    do_reset(1, 0, 1);
    check("R1 override data", data_is_mii, 0);
    check("R1 override mgmt", mgmt_is_mdio, 1);
    check("R3 addr phone hi", addr_phone, 2);
    check("R3 addr tbt hi", addr_tbt, 3);
    do_reset(0, 0, 0);
    check("R1 serial data", data_is_mii, 0);
    check("R1 serial mgmt", mgmt_is_mdio, 0);
  endtask

  task automatic t_managed;
    pin_isolate = 1; pin_src_sel = 0;
    reg_iso_phone = 0; reg_iso_tbt = 1; step();
    check("R4 phone en", out_en, 1);
    check("R4 phone sel", src_sel, 0);
    reg_iso_phone = 1; reg_iso_tbt = 0; step();
    check("R4 tbt en", out_en, 1);
    check("R4 tbt sel", src_sel, 1);
    reg_iso_phone = 1; reg_iso_tbt = 1; step();
    check("R5 hiz en", out_en, 0);
    check("R5 hiz valid", src_valid, 1);
  endtask

  task automatic t_invalid;
    pin_isolate = 1; pin_src_sel = 0;
    reg_iso_phone = 0; reg_iso_tbt = 0; step(2);
    check("R6 bad en", out_en, 0);
    check("R6 bad valid", src_valid, 0);
    check("R6 bad err", cfg_error, 1);
    reg_iso_phone = 0; reg_iso_tbt = 1; step();
    check("R6 err cleared", cfg_error, 0);
    check("R6 recovered en", out_en, 1);
  endtask

  task automatic t_external;
    reg_iso_phone = 0; reg_iso_tbt = 1;
    pin_isolate = 0; pin_src_sel = 1; step();
    check("R7 ext tbt en", out_en, 1);
    check("R7 ext tbt sel", src_sel, 1);
    reg_iso_phone = 1; reg_iso_tbt = 0;
    pin_src_sel = 0; step();
    check("R7 ext phone sel", src_sel, 0);
    check("R7 ext phone en", out_en, 1);
    reg_iso_phone = 0; reg_iso_tbt = 1;
    pin_isolate = 1; pin_src_sel = 1; step();
    check("R8 ext hiz", out_en, 0);
    check("R8 ext no err", cfg_error, 0);
  endtask

  task automatic t_stream;
    phone_valid = 1; tbt_valid = 0; rx_ready = 1;
    pin_isolate = 0; pin_src_sel = 0; step();
    check("R9 phone data", rx_data, 8'h11);
    check("R9 phone valid", rx_valid, 1);
    check("R10 phone rdy", phone_ready, 1);
    check("R10 tbt rdy off", tbt_ready, 0);
    rx_ready = 0; #1;
    check("R10 backpressure", phone_ready, 0);
    rx_ready = 1; pin_src_sel = 1; step();
    check("R9 tbt data", rx_data, 8'hA5);
    check("R9 tbt valid", rx_valid, 0);
    check("R10 tbt rdy", tbt_ready, 1);
    check("R10 phone rdy off", phone_ready, 0);
    pin_isolate = 1; step();
    check("R9 off data", rx_data, 0);
    check("R9 off valid", rx_valid, 0);
    check("R10 off rdy", {phone_ready, tbt_ready}, 0);
  endtask

  initial begin
    fork
      begin
        t_reset_state();
        t_straps();
        t_managed();
        t_invalid();
        t_external();
        t_stream();
      end
      begin
        repeat (5000) @(posedge clk);
        n_checks++; n_errors++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule